// File: doc/BRIEF.md
# Reference Divider with Binary Post-Scaler

This block takes a reference clock and produces two references for a dual frequency synthesizer. The first output is the reference clock itself, passed on without any division, for the phase detector of the first synthesizer. The second output is a single-cycle comparison pulse for the phase detector of the second synthesizer. It comes from a programmable integer counter followed by four cascaded halving stages.

A 10-bit ratio word sets the integer count R. A 3-bit tap code selects whether the comparison pulse is taken straight from the counter or after one, two, three or four halvings. The effective division is therefore R, 2R, 4R, 8R or 16R reference cycles. The output pulse is registered, so a change of the tap code cannot produce a glitch. A new tap code only matters at the cycle where the counter reaches its terminal count.

Top module: `refdiv_top`

## Requirements
- R1: While rst_ni is low, cmp_pulse_o is 0, and the ratio counter and all halving stages are cleared.
- R2: With tap code 000 and ratio R between 4 and 1023, cmp_pulse_o goes high for the first time after exactly R rising edges following reset release, and then once every R cycles.
- R3: A ratio value below 4 (0, 1, 2 or 3) behaves exactly like a ratio of 4.
- R4: Tap codes 001, 010, 011 and 100 give a pulse period of 2R, 4R, 8R and 16R cycles respectively. The first pulse after reset comes after exactly that many rising edges.
- R5: Tap codes 101, 110 and 111 behave exactly like tap code 000.
- R6: cmp_pulse_o is never high for two consecutive cycles.
- R7: The halving stages form a count of terminal counts modulo 16 that runs regardless of the tap code. On each terminal-count cycle, the tap code present in that cycle selects k halvings. The pulse is issued one cycle later when the low k bits of that count are all ones. A tap code change in any other cycle has no effect on the output.
- R8: ref_o carries the reference clock unchanged: it is high while clk_i is high and low while clk_i is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ratio_i | input | 10 | Integer division ratio R (values below 4 act as 4) |
| tap_sel_i | input | 3 | Post-scaler tap code (000 to 100, higher codes act as 000) |
| cmp_pulse_o | output | 1 | Single-cycle comparison pulse for the second phase detector |
| ref_o | output | 1 | Undivided reference for the first phase detector |

## Verification
A wrong value in the ratio counter shows up as a wrong pulse spacing. This is visible at cmp_pulse_o within one period of R cycles. A corrupted halving stage shifts the phase of the halved taps. It is caught within at most 16R cycles, as soon as a pulse lands at a terminal count where it should not, or is missing where it should appear. The bench compares the output against a behavioural model on every clock, so the first misplaced or missing pulse is flagged in the cycle it occurs. It also drives tap code changes between terminal counts, so a select that is sampled at the wrong moment shows up as a pulse at the wrong time.

// File: rtl/refdiv_pkg.sv
package refdiv_pkg;
  localparam int unsigned R_MIN = 4;

  // out-of-range tap codes fall back to the undivided counter tap
  function automatic logic [2:0] tap_decode(input logic [2:0] code, input int unsigned n_half);
    return (int'(code) > n_half) ? 3'd0 : code;
  endfunction
endpackage

// File: rtl/refdiv_rcnt.sv
module refdiv_rcnt
  import refdiv_pkg::*;
#(
  parameter int unsigned R_W = 10
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [R_W-1:0] ratio_i,
  output logic           tc_o,
  output logic [R_W-1:0] cnt_o
);
  logic [R_W-1:0] cnt_q;
  logic [R_W-1:0] lim;
  logic [R_W-1:0] last;

  assign lim  = (ratio_i < R_W'(R_MIN)) ? R_W'(R_MIN) : ratio_i;
  assign last = lim - R_W'(1);
  assign tc_o = (cnt_q >= last);
  assign cnt_o = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   cnt_q <= '0;
    else if (tc_o) cnt_q <= '0;
    else           cnt_q <= cnt_q + R_W'(1);
  end
endmodule

// File: rtl/refdiv_halver.sv
module refdiv_halver #(
  parameter int unsigned N_HALF = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tc_i,
  output logic [N_HALF-1:0] stage_o,
  output logic [N_HALF:0]   tap_o
);
  logic [N_HALF-1:0] stage_q;
  logic [N_HALF:0]   carry;

  assign carry[0] = tc_i;

  for (genvar j = 0; j < N_HALF; j++) begin : g_stage
    assign carry[j+1] = carry[j] & stage_q[j];
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       stage_q[j] <= 1'b0;
      else if (carry[j]) stage_q[j] <= ~stage_q[j];
    end
  end

  // tap j: terminal count with the j lower stages all set
  assign tap_o   = carry;
  assign stage_o = stage_q;
endmodule

// File: rtl/refdiv_tap_mux.sv
module refdiv_tap_mux
  import refdiv_pkg::*;
#(
  parameter int unsigned N_HALF = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [N_HALF:0] tap_i,
  input  logic [2:0]    sel_i,
  output logic          pulse_o
);
  logic [2:0] idx;
  logic       pulse_q;

  assign idx = tap_decode(sel_i, N_HALF);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pulse_q <= 1'b0;
    else         pulse_q <= tap_i[idx];
  end

  assign pulse_o = pulse_q;
endmodule

// File: rtl/refdiv_top.sv
module refdiv_top #(
  parameter int unsigned R_W    = 10,
  parameter int unsigned N_HALF = 4
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [R_W-1:0] ratio_i,
  input  logic [2:0]     tap_sel_i,
  output logic           cmp_pulse_o,
  output logic           ref_o
);
  logic              tc;
  logic [R_W-1:0]    r_cnt;
  logic [N_HALF-1:0] stage;
  logic [N_HALF:0]   taps;

  refdiv_rcnt #(.R_W(R_W)) u_rcnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ratio_i(ratio_i),
    .tc_o   (tc),
    .cnt_o  (r_cnt)
  );

  refdiv_halver #(.N_HALF(N_HALF)) u_halver (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tc_i   (tc),
    .stage_o(stage),
    .tap_o  (taps)
  );

  refdiv_tap_mux #(.N_HALF(N_HALF)) u_mux (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tap_i  (taps),
    .sel_i  (tap_sel_i),
    .pulse_o(cmp_pulse_o)
  );

  // direct path to the first phase detector
  assign ref_o = clk_i;
endmodule

// File: rtl/refdiv_chk.sv
module refdiv_chk #(
  parameter int unsigned R_W    = 10,
  parameter int unsigned N_HALF = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              tc,
  input logic [R_W-1:0]    r_cnt,
  input logic [N_HALF-1:0] stage,
  input logic              cmp_pulse_o
);
  // R6
  pulse_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmp_pulse_o |=> !cmp_pulse_o);

  // R7
  pulse_after_tc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cmp_pulse_o) |-> $past(tc));

  // R2
  cnt_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tc |=> (r_cnt == '0));

  // R7
  stage_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tc |=> $stable(stage));

  // R3
  tc_spacing_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tc |=> !tc);
endmodule

bind refdiv_top refdiv_chk #(.R_W(R_W), .N_HALF(N_HALF)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .tc         (tc),
  .r_cnt      (r_cnt),
  .stage      (stage),
  .cmp_pulse_o(cmp_pulse_o)
);

// File: tb/sim_refdiv_top.sv
`timescale 1ns/1ps
module sim_refdiv_top;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [9:0] ratio_i = 10'd5;
  logic [2:0] tap_sel_i = 3'd0;
  logic       cmp_pulse_o, ref_o;

  int checks = 0;
  int errors = 0;
  string cur_req = "R1";
  bit done = 0;

  refdiv_top u0 (.*);

  always #10 clk_i = ~clk_i;

  // behavioural model
  int  m_rc = 0, m_hc = 0;
  bit  m_pulse = 0;
  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_rc = 0; m_hc = 0; m_pulse = 0;
    end else begin
      int lim, k;
      bit tcm;
      lim = (ratio_i < 4) ? 4 : int'(ratio_i);
      k   = (tap_sel_i > 4) ? 0 : int'(tap_sel_i);
      tcm = (m_rc >= lim - 1);
      m_pulse = tcm && ((m_hc % (1 << k)) == (1 << k) - 1);
      if (tcm) begin m_rc = 0; m_hc = (m_hc + 1) % 16; end
      else m_rc++;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // compare on every clock, away from the active edge
  bit prev_pulse = 0;
  always @(negedge clk_i) if (rst_ni && !done) begin
    chk(cur_req, cmp_pulse_o, m_pulse);
    if (prev_pulse) chk("R6", cmp_pulse_o, 0);
    prev_pulse = cmp_pulse_o;
  end

  task automatic do_reset(input logic [9:0] r, input logic [2:0] s);
    @(negedge clk_i);
    rst_ni = 1'b0;
    ratio_i = r; tap_sel_i = s;
    prev_pulse = 0;
    #3;
    chk("R1", cmp_pulse_o, 0);
    @(negedge clk_i);
    rst_ni = 1'b1;
  endtask

  // rising edges from reset release until the first pulse
  task automatic first_pulse(input string req, input logic [9:0] r, input logic [2:0] s, input int exp);
    int n = 0;
    do_reset(r, s);
    cur_req = req;
    while (n < 20000) begin
      @(negedge clk_i);
      n++;
      if (cmp_pulse_o) break;
    end
    chk(req, n, exp);
    repeat (3 * exp) @(negedge clk_i);
  endtask

  task automatic final_report;
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    final_report();
  end

  initial begin
    do_reset(10'd5, 3'd0);
    // R8 direct reference follows the clock
    @(posedge clk_i); #5; chk("R8", ref_o, 1);
    @(negedge clk_i); #5; chk("R8", ref_o, 0);
    first_pulse("R2", 10'd5, 3'd0, 5);
    first_pulse("R2", 10'd4, 3'd0, 4);
    first_pulse("R2", 10'd1023, 3'd0, 1023);
    first_pulse("R3", 10'd0, 3'd0, 4);
    first_pulse("R3", 10'd2, 3'd1, 8);
    first_pulse("R4", 10'd6, 3'd1, 12);
    first_pulse("R4", 10'd6, 3'd2, 24);
    first_pulse("R4", 10'd6, 3'd3, 48);
    first_pulse("R4", 10'd6, 3'd4, 96);
    first_pulse("R4", 10'd4, 3'd4, 64);
    first_pulse("R5", 10'd7, 3'd5, 7);
    first_pulse("R5", 10'd7, 3'd7, 7);
    first_pulse("R5", 10'd9, 3'd6, 9);
    // R7 tap code changes at arbitrary cycles
    do_reset(10'd5, 3'd0);
    cur_req = "R7";
    for (int i = 0; i < 300; i++) begin
      @(negedge clk_i);
      if (i % 3 == 0) tap_sel_i = 3'((i / 3) % 8);
    end
    do_reset(10'd6, 3'd4);
    cur_req = "R7";
    for (int i = 0; i < 400; i++) begin
      @(negedge clk_i);
      if (i % 7 == 2) tap_sel_i = (tap_sel_i == 3'd4) ? 3'd1 : 3'd4;
    end
    final_report();
  end
endmodule